// File: doc/BRIEF.md
# Synchronous SRAM Read Output Stage

This block sits on the read-data return path of a synchronous burst SRAM, between the storage array and the data bus. Each cycle it captures a command from the access controller: read, write or deselect. In the cycle after a command is captured, the array presents its read data on `arr_rdata`. The block then either passes that data straight to the bus (flow-through) or holds it in a rising-edge output register for one more cycle (registered). The `reg_out` mode input picks between these two at run time.

Output drive is modelled as a flag, `q_drive`, rather than a real tristate pad. Whenever the flag is low, `q_data` reads as zero. A deselect removes drive as soon as the command reaches the output slot, with no extra deselect stage. The output enable `oe` and the sleep input `sleep` gate drive asynchronously. While `sleep` is high, incoming commands are discarded and any read still in flight is dropped. The array contents are not touched.

Top module: `sram_rd_out_stage`

## Requirements
- R1: With `reg_out`=0, a read command (`cmd`=2'b01) in cycle c makes `q_drive`=1 in cycle c+1, and `q_data` equals the value on `arr_rdata` during c+1. This assumes `oe`=1 and `sleep`=0.
- R2: With `reg_out`=1, a read command in cycle c makes `q_drive`=1 in cycle c+2, and `q_data` equals the value that `arr_rdata` held during c+1.
- R3: Back-to-back read commands produce data on back-to-back cycles. The first word appears in the 2nd cycle in flow-through mode and in the 3rd cycle in registered mode, counting the command cycle as the 1st.
- R4: A deselect command (`cmd`=2'b00 or 2'b11) in cycle c leaves `q_drive`=0 and `q_data`=0 in cycle c+1 in flow-through mode, or in cycle c+2 in registered mode.
- R5: `oe`=0 forces `q_drive`=0 and `q_data`=0 at once, without waiting for a clock edge. Raising `oe` again restores the pending output in the same cycle.
- R6: Raising `sleep` forces `q_drive`=0 and `q_data`=0 at once. Commands issued while `sleep` is high are ignored. Reads still in flight when a clock edge sees `sleep` high are dropped. The first clock edge after `sleep` falls captures `cmd` normally.
- R7: A write command (`cmd`=2'b10) never raises `q_drive`. In the slot where a read would have appeared, `q_data` reads 0, never the data of an earlier read.
- R8: While `rst_n` is low, and after release until a read reaches the output slot, `q_drive`=0 and `q_data`=0.
- R9: A change of `reg_out` takes effect in the same cycle. The output then shows whichever stage the new mode selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, clears the read pipeline |
| reg_out | input | 1 | 1: registered output, 0: flow-through |
| cmd | input | 2 | Command this cycle: 00/11 deselect, 01 read, 10 write |
| arr_rdata | input | DW | Array read data, valid the cycle after a captured read |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Asynchronous sleep, active high |
| q_drive | output | 1 | Output drive flag |
| q_data | output | DW | Read data, zero whenever not driven |

## Verification
This block holds only two read-valid flags and one data register. A wrong flag shows at the ports as a one-cycle drive pulse that is missing or extra. That pulse appears in the cycle after the command in flow-through mode, or two cycles after it in registered mode. A stale or unqualified data register shows up as non-zero or wrong `q_data` in the first registered-mode slot that follows a write, a deselect or a sleep. The bench therefore compares both outputs every cycle over long mixed command streams in each mode and with the mode toggling. Within each cycle it also flips `oe` and `sleep` between edges, to expose any gating that waits for a clock.

// File: rtl/sram_rd_out_stage.sv
module sram_rd_out_stage #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_out,
  input  logic [1:0]    cmd,
  input  logic [DW-1:0] arr_rdata,
  input  logic          oe,
  input  logic          sleep,
  output logic          q_drive,
  output logic [DW-1:0] q_data
);

  localparam logic [1:0] CMD_RD = 2'b01;
  localparam logic [1:0] CMD_WR = 2'b10;

  logic          s1_rd;
  logic          s2_rd;
  logic [DW-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_rd <= 1'b0;
      s2_rd <= 1'b0;
    end else begin
      s1_rd <= !sleep && (cmd == CMD_RD);
      s2_rd <= !sleep && s1_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_rd) s2_q <= arr_rdata;
  end

  logic          slot_rd;
  logic [DW-1:0] slot_q;

  assign slot_rd = reg_out ? s2_rd : s1_rd;
  assign slot_q  = reg_out ? s2_q  : arr_rdata;
  assign q_drive = slot_rd && oe && !sleep;
  assign q_data  = q_drive ? slot_q : '0;

  // R1
  flow_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD && !sleep) ##1 (!reg_out && oe && !sleep)
      |-> (q_drive && q_data == arr_rdata));

  // R2
  pipe_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD && !sleep) ##1 !sleep ##1 (reg_out && oe && !sleep)
      |-> (q_drive && q_data == $past(arr_rdata)));

  // R4
  desel_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd[0] == cmd[1]) ##1 !reg_out |-> (!q_drive && q_data == '0));

  // R4
  desel_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd[0] == cmd[1]) ##1 1'b1 ##1 reg_out |-> (!q_drive && q_data == '0));

  // R7
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_WR) ##1 1'b1 ##1 reg_out |-> (!q_drive && q_data == '0));

  // R6
  sleep_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep ##1 1'b1 ##1 reg_out |-> !q_drive);

endmodule

// File: tb/sram_rd_out_stage_bench.sv
module sram_rd_out_stage_bench;
  localparam int PERIOD = 10;
  localparam int HALF = PERIOD / 2;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_out = 1'b0;
  logic [1:0]    cmd = 2'b00;
  logic [DW-1:0] arr_rdata = '0;
  logic          oe = 1'b1;
  logic          sleep = 1'b0;
  logic          q_drive;
  logic [DW-1:0] q_data;

  sram_rd_out_stage #(.DW(DW)) u_sram_rd_out_stage (
    .clk(clk), .rst_n(rst_n), .reg_out(reg_out), .cmd(cmd),
    .arr_rdata(arr_rdata), .oe(oe), .sleep(sleep),
    .q_drive(q_drive), .q_data(q_data)
  );

  always #(HALF) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [1:0]    p1_cmd = 2'b00, p2_cmd = 2'b00;
  logic          p1_slp = 1'b0, p2_slp = 1'b0;
  logic [DW-1:0] p1_arr = '0;
  logic [15:0]   lfsr = 16'hACE1;

  task automatic chk(input string tag, input logic ad, input logic [DW-1:0] aq,
                     input logic ed, input logic [DW-1:0] eq);
    n_cmp++;
    if (ad !== ed || aq !== eq) begin
      n_bad++;
      $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h", tag, ad, aq, ed, eq);
    end
  endtask

  task automatic cycle(input logic [1:0] c, input logic [DW-1:0] a, input logic s,
                       input logic o, input logic m, input string grp);
    logic rd_in;
    logic [DW-1:0] dat;
    logic [1:0] rel;
    string tag;
    cmd = c; arr_rdata = a; sleep = s; oe = o; reg_out = m;
    #(HALF - 1);
    rd_in = m ? (p2_cmd == 2'b01 && !p2_slp && !p1_slp) : (p1_cmd == 2'b01 && !p1_slp);
    dat = m ? p1_arr : a;
    rel = m ? p2_cmd : p1_cmd;
    if (s) tag = "R6";
    else if (!o) tag = "R5";
    else if (rd_in) tag = grp;
    else if (rel == 2'b01) tag = "R6";
    else if (rel == 2'b10) tag = "R7";
    else tag = "R4";
    chk(tag, q_drive, q_data, rd_in && o && !s, (rd_in && o && !s) ? dat : '0);
    oe = !o; #1;
    chk("R5", q_drive, q_data, rd_in && !o && !s, (rd_in && !o && !s) ? dat : '0);
    oe = o; #1;
    if (!s) begin
      sleep = 1'b1; #1;
      chk("R6", q_drive, q_data, 1'b0, '0);
      sleep = 1'b0; #1;
    end
    p2_cmd = p1_cmd; p2_slp = p1_slp;
    p1_cmd = c; p1_slp = s; p1_arr = a;
    @(posedge clk); #1;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: drive=%0b data=%h expected drive=0 data=0", q_drive, q_data);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cmd = 2'b01; arr_rdata = 32'hDEAD_BEEF; oe = 1'b1;
    for (int i = 0; i < 4; i++) begin
      reg_out = i[0];
      @(negedge clk);
      chk("R8", q_drive, q_data, 1'b0, '0);
    end
    cmd = 2'b00;
    @(posedge clk); #1;
    rst_n = 1'b1;
    cycle(2'b00, 32'h1111_1111, 1'b0, 1'b1, 1'b0, "R8");
    cycle(2'b00, 32'h2222_2222, 1'b0, 1'b1, 1'b1, "R8");

    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 8; k++)
        cycle(k < 4 ? 2'b01 : 2'b00, 32'hB000_0000 + 32'(k) + 32'(m << 8),
              1'b0, 1'b1, m[0], "R3");
      cycle(2'b10, 32'hC0DE_0000, 1'b0, 1'b1, m[0], "R7");
      cycle(2'b00, 32'hC0DE_0001, 1'b0, 1'b1, m[0], "R7");
      cycle(2'b00, 32'hC0DE_0002, 1'b0, 1'b1, m[0], "R7");
    end

    for (int pass = 0; pass < 3; pass++) begin
      for (int k = 0; k < 400; k++) begin
        logic [1:0] c;
        logic s, o, m;
        string g;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        c = (lfsr[3:2] == 2'b00) ? lfsr[1:0] : 2'b01;
        s = (lfsr[7:4] == 4'h0);
        o = (lfsr[11:9] != 3'h0);
        m = (pass == 2) ? lfsr[13] : pass[0];
        g = (pass == 0) ? "R1" : (pass == 1) ? "R2" : "R9";
        cycle(c, {lfsr, ~lfsr ^ 16'(k)}, s, o, m, g);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule